// File: doc/BRIEF.md
# Linked-descriptor stream mover

This block is the memory-to-stream half of a DMA channel. Given the address of a first data descriptor and of the parent context descriptor, it fetches each four-word descriptor over a simple request/acknowledge memory port. It then reads the byte range that descriptor delimits and presents the bytes one per beat on a valid/ready stream. At the end of every descriptor it writes the descriptor back, may raise an interrupt request, and follows the next pointer. A descriptor flagged as the last of the list stops the mover. The mover then sets a disable bit in the context descriptor.

Every buffer is described by a start pointer and an exclusive end pointer, not by a length, so a descriptor whose two pointers are equal is legal and moves nothing. A metadata beat carrying sixteen bits from the descriptor opens each packet. The last byte of a descriptor can carry an end-of-packet marker. A register block drives start and stop and collects the interrupt-set pulses.

Top module: `dsc_stream_mover`

## Requirements
- R1: Out of reset the mover is idle: no memory request, no stream beat, end-of-list and busy low, no interrupt pulse.
- R2: A descriptor is four 32-bit words at consecutive word addresses from its pointer: +0 next pointer, +4 buffer start, +8 flag word, +12 end pointer (one past the last byte). The bytes from start up to end are streamed in address order. Within a fetched word, byte lane 0 (bits 7:0) holds the lowest address.
- R3: A metadata beat (`st_is_meta_o`=1, `st_meta_o` = flag word bits 31:16) precedes the first data of the first descriptor after a start. One also precedes the data of every descriptor that follows one with the output end-of-packet flag (flag bit 3). No other metadata beats appear.
- R4: `st_last_o` is high on the final byte of a descriptor exactly when its flag bit 3 is set, and on no other beat.
- R5: When a descriptor completes, `intr_set_o` bit 2 pulses for one cycle if flag bit 4 is set. The other bits of `intr_set_o` stay zero.
- R6: A completed descriptor's four words are written back unchanged to their own addresses, in order +0..+12, before the next descriptor is fetched.
- R7: If the completed descriptor has flag bit 0 (end of list) set, the mover reads the context flag word at context address +4. It writes that word back with bit 15 set and its other bits kept, then raises `eol_o` and drops `busy_o`.
- R8: While `eol_o` is high the mover issues no memory request and no stream beat. A `start_i` pulse clears `eol_o` and walks a new list.
- R9: While a beat is held by `st_ready_i` low, `st_valid_o` stays high and the beat's fields stay stable. No byte is lost or repeated.
- R10: A memory request keeps its address, direction and write data until acknowledged, and each access completes exactly once.
- R11: A descriptor whose end equals its start streams no data byte. It still completes with interrupt, write-back and metadata handling as above.
- R12: Bytes are moved in chunks of at most `CHUNK_BYTES`, counted from each descriptor's start. A `stop_i` pulse takes effect at the next chunk or descriptor boundary. Busy then falls with `eol_o` low, and `pos_o` holds the address of the next unsent byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a list walk (taken when idle) |
| stop_i | input | 1 | Request a halt at the next boundary |
| start_addr_i | input | 32 | Address of the first data descriptor |
| ctx_addr_i | input | 32 | Address of the parent context descriptor |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access done; read data valid |
| mem_rdata_i | input | 32 | Read data |
| st_valid_o | output | 1 | Stream beat valid |
| st_ready_i | input | 1 | Stream sink ready |
| st_data_o | output | 8 | Data byte (zero on metadata beats) |
| st_last_o | output | 1 | End-of-packet marker |
| st_is_meta_o | output | 1 | Beat carries metadata, not data |
| st_meta_o | output | 16 | Metadata of the current descriptor |
| intr_set_o | output | 4 | Raw interrupt set pulses; bit 2 = descriptor done |
| busy_o | output | 1 | Mover is walking a list |
| eol_o | output | 1 | End of list reached |
| pos_o | output | 32 | Saved buffer position |
| desc_o | output | 32 | Current descriptor address |

## Verification
A directed list mixes an unaligned packet-ending descriptor, a zero-length descriptor without end-of-packet and an end-of-list descriptor with unused flag bits set. It separates the metadata rule (after packet end only) from a per-descriptor rule and shows that unused flags have no effect. Random lists of one to four descriptors with random lengths, alignments, flags, acknowledge delays and sink stalls are compared beat by beat and write by write against a model built from the memory image. They separate correct lane order, end handling and back-pressure from byte loss or duplication. A long descriptor stopped mid-chunk shows that a halt lands exactly on the chunk boundary with the right saved position. The run afterwards shows a clean restart.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
   // flag word bit positions (descriptor word 2)
   localparam int unsigned FLG_EOL      = 0;
   localparam int unsigned FLG_OUT_EOP  = 3;
   localparam int unsigned FLG_INTR     = 4;
   localparam int unsigned META_LSB     = 16;
   localparam int unsigned META_W       = 16;
   // raw interrupt bit raised on descriptor completion
   localparam int unsigned IRQ_DONE_BIT = 2;
   localparam int unsigned IRQ_W        = 4;
   // descriptor word indices
   localparam int unsigned DW_NEXT  = 0;
   localparam int unsigned DW_START = 1;
   localparam int unsigned DW_FLAGS = 2;
   localparam int unsigned DW_END   = 3;
   localparam int unsigned DESC_WORDS = 4;

   typedef enum logic [3:0] {
      MV_IDLE,
      MV_LOAD,
      MV_META,
      MV_RDW,
      MV_PUSH,
      MV_DONE,
      MV_WBACK,
      MV_CTX_RD,
      MV_CTX_WR
   } mv_state_t;
endpackage

// File: rtl/dsm_desc_file.sv
module dsm_desc_file #(
   parameter int unsigned WORDS = 4,
   parameter int unsigned WW    = 32,
   localparam int unsigned IW   = $clog2(WORDS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IW-1:0]              wr_idx,
   input  logic [WW-1:0]              wr_data,
   input  logic [IW-1:0]              rd_idx,
   output logic [WW-1:0]              rd_data,
   output logic [WORDS-1:0][WW-1:0]   words_o
);
   for (genvar g = 0; g < WORDS; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)
            words_o[g] <= '0;
         else if (wr_en && (wr_idx == IW'(g)))
            words_o[g] <= wr_data;
      end
   end

   assign rd_data = words_o[rd_idx];
endmodule

// File: rtl/dsm_lane_pick.sv
module dsm_lane_pick #(
   parameter int unsigned LANES     = 4,
   parameter bit          MSB_FIRST = 1'b0,
   localparam int unsigned LW       = $clog2(LANES)
) (
   input  logic [8*LANES-1:0] word_i,
   input  logic [LW-1:0]      lane_i,
   output logic [7:0]         byte_o
);
   logic [7:0] lane_byte [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      if (MSB_FIRST) begin : g_hi
         assign lane_byte[g] = word_i[8*(LANES-1-g) +: 8];
      end else begin : g_lo
         assign lane_byte[g] = word_i[8*g +: 8];
      end
   end

   assign byte_o = lane_byte[lane_i];
endmodule

// File: rtl/dsc_stream_mover.sv
module dsc_stream_mover #(
   parameter int unsigned CHUNK_BYTES  = 2048,
   parameter int unsigned CTX_FLAG_OFS = 4,
   parameter int unsigned CTX_DIS_BIT  = 15,
   parameter bit          MSB_FIRST    = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic        stop_i,
   input  logic [31:0] start_addr_i,
   input  logic [31:0] ctx_addr_i,
   output logic        mem_req_o,
   output logic        mem_we_o,
   output logic [31:0] mem_addr_o,
   output logic [31:0] mem_wdata_o,
   input  logic        mem_ack_i,
   input  logic [31:0] mem_rdata_i,
   output logic        st_valid_o,
   input  logic        st_ready_i,
   output logic [7:0]  st_data_o,
   output logic        st_last_o,
   output logic        st_is_meta_o,
   output logic [15:0] st_meta_o,
   output logic [3:0]  intr_set_o,
   output logic        busy_o,
   output logic        eol_o,
   output logic [31:0] pos_o,
   output logic [31:0] desc_o
);
   import dsm_pkg::*;

   localparam int unsigned LANES = 4;
   localparam int unsigned LW    = $clog2(LANES);
   localparam int unsigned IW    = $clog2(DESC_WORDS);
   localparam int unsigned CNT_W = (CHUNK_BYTES > 2) ? $clog2(CHUNK_BYTES) : 1;
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CHUNK_BYTES - 1);

   // elaboration-time parameter checks
   if (CHUNK_BYTES < 2) begin : g_bad_chunk
      $error("CHUNK_BYTES must be at least 2");
   end
   if (CTX_DIS_BIT > 31) begin : g_bad_dis
      $error("CTX_DIS_BIT must index a 32-bit word");
   end
   if ((CTX_FLAG_OFS % 4) != 0) begin : g_bad_ofs
      $error("CTX_FLAG_OFS must be word aligned");
   end

   mv_state_t          state;
   logic [IW-1:0]      wcnt;
   logic [31:0]        desc_ptr;
   logic [31:0]        ctx_ptr;
   logic [31:0]        pos;
   logic [31:0]        word_q;
   logic [31:0]        ctx_word;
   logic [CNT_W-1:0]   chunk_cnt;
   logic               send_meta;
   logic               eol_q;
   logic               stop_pend;

   logic                              dfile_we;
   logic [31:0]                       dfile_rd;
   logic [DESC_WORDS-1:0][31:0]       dwords;
   logic [31:0]                       flags;
   logic [31:0]                       end_ptr;
   logic [7:0]                        lane_byte;
   logic                              last_byte;

   assign dfile_we = (state == MV_LOAD) && mem_ack_i;

   dsm_desc_file #(.WORDS(DESC_WORDS), .WW(32)) u_dfile (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (dfile_we),
      .wr_idx  (wcnt),
      .wr_data (mem_rdata_i),
      .rd_idx  (wcnt),
      .rd_data (dfile_rd),
      .words_o (dwords)
   );

   dsm_lane_pick #(.LANES(LANES), .MSB_FIRST(MSB_FIRST)) u_lane (
      .word_i (word_q),
      .lane_i (pos[LW-1:0]),
      .byte_o (lane_byte)
   );

   assign flags     = dwords[DW_FLAGS];
   assign end_ptr   = dwords[DW_END];
   assign last_byte = ((pos + 32'd1) == end_ptr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= MV_IDLE;
         wcnt      <= '0;
         desc_ptr  <= '0;
         ctx_ptr   <= '0;
         pos       <= '0;
         word_q    <= '0;
         ctx_word  <= '0;
         chunk_cnt <= '0;
         send_meta <= 1'b0;
         eol_q     <= 1'b0;
         stop_pend <= 1'b0;
      end else begin
         if (stop_i && (state != MV_IDLE))
            stop_pend <= 1'b1;
         case (state)
            MV_IDLE: begin
               stop_pend <= 1'b0;
               if (start_i) begin
                  desc_ptr  <= start_addr_i;
                  ctx_ptr   <= ctx_addr_i;
                  eol_q     <= 1'b0;
                  send_meta <= 1'b1;
                  wcnt      <= '0;
                  state     <= MV_LOAD;
               end
            end
            MV_LOAD: begin
               if (mem_ack_i) begin
                  wcnt <= wcnt + 1'b1;
                  if (wcnt == IW'(DW_END - 1))
                     pos <= dwords[DW_START];
                  if (wcnt == IW'(DW_END)) begin
                     wcnt      <= '0;
                     chunk_cnt <= '0;
                     if (send_meta)
                        state <= MV_META;
                     else if (pos == mem_rdata_i)
                        state <= MV_DONE;
                     else
                        state <= MV_RDW;
                  end
               end
            end
            MV_META: begin
               if (st_ready_i) begin
                  send_meta <= 1'b0;
                  state     <= (pos == end_ptr) ? MV_DONE : MV_RDW;
               end
            end
            MV_RDW: begin
               if (mem_ack_i) begin
                  word_q <= mem_rdata_i;
                  state  <= MV_PUSH;
               end
            end
            MV_PUSH: begin
               if (st_ready_i) begin
                  pos <= pos + 32'd1;
                  if (last_byte) begin
                     state <= MV_DONE;
                  end else if (chunk_cnt == CNT_TOP) begin
                     chunk_cnt <= '0;
                     if (stop_pend || stop_i) begin
                        stop_pend <= 1'b0;
                        state     <= MV_IDLE;
                     end else begin
                        state <= MV_RDW;
                     end
                  end else begin
                     chunk_cnt <= chunk_cnt + 1'b1;
                     if (pos[LW-1:0] == LW'(LANES - 1))
                        state <= MV_RDW;
                  end
               end
            end
            MV_DONE: begin
               if (flags[FLG_OUT_EOP])
                  send_meta <= 1'b1;
               wcnt  <= '0;
               state <= MV_WBACK;
            end
            MV_WBACK: begin
               if (mem_ack_i) begin
                  wcnt <= wcnt + 1'b1;
                  if (wcnt == IW'(DESC_WORDS - 1)) begin
                     wcnt <= '0;
                     if (flags[FLG_EOL]) begin
                        state <= MV_CTX_RD;
                     end else begin
                        desc_ptr <= dwords[DW_NEXT];
                        if (stop_pend || stop_i) begin
                           stop_pend <= 1'b0;
                           state     <= MV_IDLE;
                        end else begin
                           state <= MV_LOAD;
                        end
                     end
                  end
               end
            end
            MV_CTX_RD: begin
               if (mem_ack_i) begin
                  ctx_word <= mem_rdata_i | (32'd1 << CTX_DIS_BIT);
                  state    <= MV_CTX_WR;
               end
            end
            MV_CTX_WR: begin
               if (mem_ack_i) begin
                  eol_q     <= 1'b1;
                  stop_pend <= 1'b0;
                  state     <= MV_IDLE;
               end
            end
            default: state <= MV_IDLE;
         endcase
      end
   end

   // memory port
   always_comb begin
      mem_req_o   = 1'b0;
      mem_we_o    = 1'b0;
      mem_addr_o  = '0;
      mem_wdata_o = '0;
      case (state)
         MV_LOAD: begin
            mem_req_o  = 1'b1;
            mem_addr_o = desc_ptr + (32'(wcnt) << 2);
         end
         MV_RDW: begin
            mem_req_o  = 1'b1;
            mem_addr_o = {pos[31:LW], {LW{1'b0}}};
         end
         MV_WBACK: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = desc_ptr + (32'(wcnt) << 2);
            mem_wdata_o = dfile_rd;
         end
         MV_CTX_RD: begin
            mem_req_o  = 1'b1;
            mem_addr_o = ctx_ptr + 32'(CTX_FLAG_OFS);
         end
         MV_CTX_WR: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = ctx_ptr + 32'(CTX_FLAG_OFS);
            mem_wdata_o = ctx_word;
         end
         default: ;
      endcase
   end

   // stream port
   assign st_valid_o   = (state == MV_META) || (state == MV_PUSH);
   assign st_is_meta_o = (state == MV_META);
   assign st_data_o    = (state == MV_PUSH) ? lane_byte : 8'h00;
   assign st_last_o    = (state == MV_PUSH) && last_byte && flags[FLG_OUT_EOP];
   assign st_meta_o    = flags[META_LSB +: META_W];

   always_comb begin
      intr_set_o = '0;
      intr_set_o[IRQ_DONE_BIT] = (state == MV_DONE) && flags[FLG_INTR];
   end

   assign busy_o = (state != MV_IDLE);
   assign eol_o  = eol_q;
   assign pos_o  = pos;
   assign desc_o = desc_ptr;
endmodule

// File: rtl/dsm_stream_mover_chk.sv
module dsm_stream_mover_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        start_i,
   input logic        stop_i,
   input logic [31:0] start_addr_i,
   input logic [31:0] ctx_addr_i,
   input logic        mem_req_o,
   input logic        mem_we_o,
   input logic [31:0] mem_addr_o,
   input logic [31:0] mem_wdata_o,
   input logic        mem_ack_i,
   input logic [31:0] mem_rdata_i,
   input logic        st_valid_o,
   input logic        st_ready_i,
   input logic [7:0]  st_data_o,
   input logic        st_last_o,
   input logic        st_is_meta_o,
   input logic [15:0] st_meta_o,
   input logic [3:0]  intr_set_o,
   input logic        busy_o,
   input logic        eol_o,
   input logic [31:0] pos_o,
   input logic [31:0] desc_o
);
   // R9: a stalled beat is held unchanged
   p_beat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid_o && !st_ready_i |=> st_valid_o && $stable(st_data_o) && $stable(st_last_o)
                                    && $stable(st_is_meta_o) && $stable(st_meta_o));

   // R10: an unacknowledged request is held unchanged
   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                  && $stable(mem_wdata_o));

   // R8: nothing moves while end of list is flagged
   p_quiet_eol_r8: assert property (@(posedge clk) disable iff (!rst_n)
      eol_o |-> !mem_req_o && !st_valid_o);

   // R4: the end-of-packet marker rides only on data beats
   p_last_on_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid_o && st_last_o |-> !st_is_meta_o);

   // R5 / R6: a done interrupt is a single pulse followed by write-back
   p_intr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      intr_set_o[2] |=> !intr_set_o[2] && mem_req_o && mem_we_o);

   // R7: end of list rises only after an acknowledged write, with busy low
   p_eol_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eol_o) |-> !busy_o && $past(mem_req_o && mem_we_o && mem_ack_i));

   // R1: idle mover makes no memory request
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !mem_req_o && !st_valid_o && (intr_set_o == 4'b0000));
endmodule

bind dsc_stream_mover dsm_stream_mover_chk u_chk (.*);

// File: tb/dsc_stream_mover_test.sv
module dsc_stream_mover_test;
   localparam int CHUNK = 16;
   localparam logic [31:0] CTX = 32'h0000_0F00;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        stop_i = 1'b0;
   logic [31:0] start_addr_i = '0;
   logic [31:0] ctx_addr_i = '0;
   logic        mem_req_o, mem_we_o, mem_ack_i;
   logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
   logic        st_valid_o, st_ready_i, st_last_o, st_is_meta_o;
   logic [7:0]  st_data_o;
   logic [15:0] st_meta_o;
   logic [3:0]  intr_set_o;
   logic        busy_o, eol_o;
   logic [31:0] pos_o, desc_o;

   always #5 clk = ~clk;

   dsc_stream_mover #(.CHUNK_BYTES(CHUNK)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
      .start_addr_i(start_addr_i), .ctx_addr_i(ctx_addr_i),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
      .st_valid_o(st_valid_o), .st_ready_i(st_ready_i), .st_data_o(st_data_o),
      .st_last_o(st_last_o), .st_is_meta_o(st_is_meta_o), .st_meta_o(st_meta_o),
      .intr_set_o(intr_set_o), .busy_o(busy_o), .eol_o(eol_o),
      .pos_o(pos_o), .desc_o(desc_o)
   );

   logic [31:0] mem [0:1023];
   int n_chk = 0, n_bad = 0;
   int ack_dly_max = 0, rdy_pct = 100;
   int dly_cnt = 0;
   bit ack_on = 0;

   logic [31:0] wr_a [0:63];
   logic [31:0] wr_d [0:63];
   int wr_n = 0;
   logic [25:0] got [0:1023];
   int got_n = 0;
   int intr_n = 0, intr_bad = 0, stall_bad = 0, quiet_bad = 0;
   bit mon_quiet = 0;
   bit have_stall = 0;
   logic [25:0] stall_beat;

   // descriptor list under test
   logic [31:0] d_addr [0:7];
   logic [31:0] d_buf  [0:7];
   logic [31:0] d_end  [0:7];
   logic [31:0] d_flg  [0:7];
   int n_d = 0;
   logic [31:0] ctx_orig;

   logic [25:0] exp_b [0:1023];
   int exp_n = 0;
   logic [31:0] ew_a [0:63];
   logic [31:0] ew_d [0:63];
   int ew_n = 0;
   int exp_intr = 0;

   function automatic logic [25:0] beat_of(input logic m, input logic l,
                                           input logic [15:0] md, input logic [7:0] d);
      return m ? {1'b1, 1'b0, md, 8'h00} : {1'b0, l, 16'h0000, d};
   endfunction

   function automatic logic [7:0] mem_byte(input logic [31:0] a);
      logic [31:0] w;
      w = mem[a[11:2]];
      return w[8*a[1:0] +: 8];
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // memory responder and stream sink, driven between clock edges
   initial begin
      mem_ack_i = 1'b0;
      mem_rdata_i = '0;
      st_ready_i = 1'b0;
      forever begin
         @(negedge clk);
         if (ack_on) begin
            mem_ack_i = 1'b0;
            ack_on = 0;
         end else if (mem_req_o && rst_n) begin
            if (dly_cnt > 0) dly_cnt--;
            else begin
               if (mem_we_o) begin
                  mem[mem_addr_o[11:2]] = mem_wdata_o;
                  if (wr_n < 64) begin
                     wr_a[wr_n] = mem_addr_o;
                     wr_d[wr_n] = mem_wdata_o;
                  end
                  wr_n++;
               end else begin
                  mem_rdata_i = mem[mem_addr_o[11:2]];
               end
               mem_ack_i = 1'b1;
               ack_on = 1;
               dly_cnt = $urandom_range(ack_dly_max, 0);
            end
         end
         st_ready_i = ($urandom_range(99, 0) < rdy_pct);
         if (have_stall) begin
            if (!st_valid_o ||
                beat_of(st_is_meta_o, st_last_o, st_meta_o, st_data_o) != stall_beat)
               stall_bad++;
         end
         have_stall = 0;
         if (st_valid_o && rst_n) begin
            if (st_ready_i) begin
               if (got_n < 1024)
                  got[got_n] = beat_of(st_is_meta_o, st_last_o, st_meta_o, st_data_o);
               got_n++;
            end else begin
               have_stall = 1;
               stall_beat = beat_of(st_is_meta_o, st_last_o, st_meta_o, st_data_o);
            end
         end
         if (intr_set_o[2]) intr_n++;
         if ((intr_set_o & 4'b1011) != 4'b0000) intr_bad++;
         if (mon_quiet && (mem_req_o || st_valid_o)) quiet_bad++;
      end
   end

   // watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   task automatic write_list();
      for (int i = 0; i < n_d; i++) begin
         mem[d_addr[i][11:2] + 0] = (i + 1 < n_d) ? d_addr[i+1] : 32'h0000_0FF0;
         mem[d_addr[i][11:2] + 1] = d_buf[i];
         mem[d_addr[i][11:2] + 2] = d_flg[i];
         mem[d_addr[i][11:2] + 3] = d_end[i];
      end
   endtask

   task automatic build_expect();
      bit sm;
      sm = 1;
      exp_n = 0;
      ew_n = 0;
      exp_intr = 0;
      for (int i = 0; i < n_d; i++) begin
         if (sm) begin
            exp_b[exp_n] = beat_of(1'b1, 1'b0, d_flg[i][31:16], 8'h00);
            exp_n++;
            sm = 0;
         end
         for (logic [31:0] a = d_buf[i]; a < d_end[i]; a++) begin
            exp_b[exp_n] = beat_of(1'b0, (a == d_end[i] - 1) && d_flg[i][3], 16'h0, mem_byte(a));
            exp_n++;
         end
         if (d_flg[i][3]) sm = 1;
         if (d_flg[i][4]) exp_intr++;
         for (int k = 0; k < 4; k++) begin
            ew_a[ew_n] = d_addr[i] + 32'(4 * k);
            ew_d[ew_n] = mem[d_addr[i][11:2] + k];
            ew_n++;
         end
      end
      ew_a[ew_n] = CTX + 32'd4;
      ew_d[ew_n] = ctx_orig | 32'h0000_8000;
      ew_n++;
   endtask

   task automatic clear_logs();
      got_n = 0; wr_n = 0; intr_n = 0; intr_bad = 0; stall_bad = 0;
   endtask

   task automatic pulse_start(input logic [31:0] a);
      @(negedge clk);
      start_addr_i = a;
      ctx_addr_i = CTX;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic run_list(input string tag);
      int t, bad_i, m_got, m_exp, l_got, l_exp;
      clear_logs();
      mem[CTX[11:2] + 1] = ctx_orig;
      write_list();
      build_expect();
      pulse_start(d_addr[0]);
      t = 0;
      while (!eol_o && t < 20000) begin
         @(negedge clk);
         t++;
      end
      repeat (3) @(negedge clk);
      check(got_n == exp_n, "R2", {tag, " beat count"}, got_n, exp_n);
      bad_i = -1;
      m_got = 0; m_exp = 0; l_got = 0; l_exp = 0;
      for (int i = 0; i < got_n && i < 1024; i++) begin
         m_got += got[i][25]; l_got += got[i][24];
      end
      for (int i = 0; i < exp_n; i++) begin
         m_exp += exp_b[i][25]; l_exp += exp_b[i][24];
         if (bad_i < 0 && (i >= got_n || got[i] != exp_b[i])) bad_i = i;
      end
      check(bad_i < 0, "R2", {tag, " beat content (first bad index)"}, bad_i, -1);
      check(m_got == m_exp, "R3", {tag, " metadata beats"}, m_got, m_exp);
      check(l_got == l_exp, "R4", {tag, " end-of-packet beats"}, l_got, l_exp);
      check(stall_bad == 0, "R9", {tag, " stalled beat changed"}, stall_bad, 0);
      check(intr_n == exp_intr, "R5", {tag, " done interrupts"}, intr_n, exp_intr);
      check(intr_bad == 0, "R5", {tag, " stray interrupt bits"}, intr_bad, 0);
      check(wr_n == ew_n, "R10", {tag, " write count"}, wr_n, ew_n);
      bad_i = -1;
      for (int i = 0; i < ew_n && i < 64; i++)
         if (bad_i < 0 && (i >= wr_n || wr_a[i] != ew_a[i] || wr_d[i] != ew_d[i])) bad_i = i;
      check(bad_i < 0, "R6", {tag, " write-back sequence (first bad index)"}, bad_i, -1);
      check(mem[CTX[11:2] + 1] == (ctx_orig | 32'h0000_8000), "R7", {tag, " context flag word"},
            mem[CTX[11:2] + 1], ctx_orig | 32'h0000_8000);
      check(eol_o && !busy_o, "R7", {tag, " eol high, busy low"}, {eol_o, busy_o}, 2'b10);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 1024; i++) mem[i] = $urandom();
      repeat (4) @(negedge clk);
      // R1: reset state
      check(!mem_req_o, "R1", "mem_req after reset", mem_req_o, 0);
      check(!st_valid_o, "R1", "st_valid after reset", st_valid_o, 0);
      check(!eol_o && !busy_o, "R1", "eol/busy after reset", {eol_o, busy_o}, 0);
      check(intr_set_o == 4'b0000, "R1", "intr after reset", intr_set_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // directed list: unaligned packet, zero-length (R11), end of list with unused flags
      ack_dly_max = 0; rdy_pct = 100;
      n_d = 3;
      d_addr[0] = 32'h800; d_buf[0] = 32'h101; d_end[0] = 32'h10A; d_flg[0] = 32'hA1B2_0038;
      d_addr[1] = 32'h840; d_buf[1] = 32'h200; d_end[1] = 32'h200; d_flg[1] = 32'h1111_0010;
      d_addr[2] = 32'h880; d_buf[2] = 32'h203; d_end[2] = 32'h209; d_flg[2] = 32'h2222_0809;
      ctx_orig = 32'h0000_1234;
      run_list("directed");
      // R11: zero-length descriptor yields its metadata beat directly followed by the next data
      check(got[10] == beat_of(1'b1, 1'b0, 16'h1111, 8'h00) && got[11][25] == 1'b0,
            "R11", "zero-length descriptor beats", got[10], beat_of(1'b1, 1'b0, 16'h1111, 8'h00));

      // R8: quiet while end of list is flagged
      mon_quiet = 1;
      quiet_bad = 0;
      repeat (30) @(negedge clk);
      mon_quiet = 0;
      check(quiet_bad == 0, "R8", "activity while eol high", quiet_bad, 0);
      check(eol_o, "R8", "eol holds without start", eol_o, 1);

      // R12: stop lands on a chunk boundary
      clear_logs();
      n_d = 1;
      d_addr[0] = 32'h900; d_buf[0] = 32'h100; d_end[0] = 32'h128; d_flg[0] = 32'h5A5A_0008;
      write_list();
      pulse_start(d_addr[0]);
      check(!eol_o && busy_o, "R8", "start clears eol", {eol_o, busy_o}, 2'b01);
      begin
         int t = 0;
         while (got_n < 2 && t < 2000) begin @(negedge clk); t++; end
         stop_i = 1'b1;
         @(negedge clk);
         stop_i = 1'b0;
         t = 0;
         while (busy_o && t < 2000) begin @(negedge clk); t++; end
      end
      repeat (3) @(negedge clk);
      check(got_n == 1 + CHUNK, "R12", "beats before stop", got_n, 1 + CHUNK);
      check(pos_o == 32'h100 + CHUNK, "R12", "saved position after stop", pos_o, 32'h100 + CHUNK);
      check(!eol_o && !busy_o, "R12", "stopped state", {eol_o, busy_o}, 0);
      check(got[CHUNK] == beat_of(1'b0, 1'b0, 16'h0, mem_byte(32'h100 + CHUNK - 1)), "R12",
            "last byte before stop", got[CHUNK], beat_of(1'b0, 1'b0, 16'h0, mem_byte(32'h100 + CHUNK - 1)));

      // random lists with random acknowledge delay and sink stalls (R9, R10)
      ack_dly_max = 3; rdy_pct = 60;
      for (int it = 0; it < 10; it++) begin
         for (int i = 0; i < 512; i++) mem[i] = $urandom();
         n_d = $urandom_range(4, 1);
         for (int i = 0; i < n_d; i++) begin
            int len;
            d_addr[i] = 32'h800 + 32'(((i * 3) % 8) * 32);
            d_buf[i]  = 32'(i * 256) + 32'($urandom_range(15, 0));
            len = ($urandom_range(3, 0) == 0) ? 0 : $urandom_range(40, 1);
            d_end[i]  = d_buf[i] + 32'(len);
            d_flg[i]  = {16'($urandom()), 16'($urandom()) & 16'h7FE6};
            d_flg[i][3] = 1'($urandom_range(1, 0));
            d_flg[i][4] = 1'($urandom_range(1, 0));
            d_flg[i][0] = (i == n_d - 1);
         end
         ctx_orig = $urandom() & 32'hFFFF_7FFF;
         run_list($sformatf("random%0d", it));
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule